// File: doc/BRIEF.md
# Scalar Double Move Execution Unit

This unit carries out a single 64-bit floating-point value move between an array of 128-bit vector registers and 64-bit memory. A decoder upstream hands it the three opcode bytes, the operand-addressing byte and, for loads, the 64-bit word already read from memory. The unit decides the direction and the operand kinds. It updates its own register array or presents a 64-bit word on a memory write port, and it returns a fault code for each request.

The way the destination register changes depends on the kind of move. A move between two registers replaces only the low 64 bits. A load from memory replaces the low 64 bits and zeroes the high 64 bits. A store leaves every register as it was and sends out only the low 64 bits of the source.

Three control bits and one feature bit enable the operation. Address translation and protection checks happen elsewhere, and their outcome arrives as one external fault input that is only reported. The value being moved is never interpreted, so the unit raises no arithmetic status. Each request completes one clock after it is accepted, and a new request can be accepted every cycle.

Top module: `sdm_exec`

## Requirements
- R1: The unit recognises a request only when the opcode bytes are 0xF2, 0x0F and then 0x10 (load direction) or 0x11 (store direction). Any other byte sequence returns fault code 1 and changes no state.
- R2: Addressing byte bits 7:6 equal to 2'b11 select a register-to-register form. Otherwise the second operand is memory. Bits 5:3 index the register-field operand and bits 2:0 index the second register.
- R3: A fault-free register-to-register load copies bits 63:0 of register [2:0] into bits 63:0 of register [5:3]. Bits 127:64 of register [5:3] keep their value.
- R4: A fault-free memory load writes mem_rdata into bits 63:0 of register [5:3] and clears bits 127:64 of that register.
- R5: A fault-free memory store pulses mem_we for one cycle with mem_wdata equal to bits 63:0 of register [5:3]. No register changes.
- R6: A fault-free register-to-register store copies bits 63:0 of register [5:3] into bits 63:0 of register [2:0]. Bits 127:64 of register [2:0] keep their value.
- R7: Fault code 1 (invalid operation) is returned when ctl_emulate is 1, when ctl_os_save_ok is 0, or when feat_f64_vec is 0. This fault outranks every other fault.
- R8: Fault code 2 (unit unavailable) is returned when ctl_task_switched is 1 and no code-1 condition holds. It outranks code 3.
- R9: Fault code 3 is returned when ext_fault is 1 on a memory form and no higher fault applies. On register-to-register forms, ext_fault is ignored.
- R10: Any nonzero fault code suppresses every register write and the memory write.
- R11: done is 1 in exactly the cycle after each accepted request. fault_code is valid with done and is 0 whenever done is 0. Back-to-back requests see the results of the request before them.
- R12: After reset, done, mem_we and fault_code are 0, and register i holds RF_RESET_BASE XOR i.
- R13: Data moves bit for bit, so a NaN pattern arrives unchanged and produces no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_prefix | input | 8 | First opcode byte |
| req_escape | input | 8 | Second opcode byte |
| req_opcode | input | 8 | Third opcode byte, gives the direction |
| req_modrm | input | 8 | Addressing byte |
| mem_rdata | input | QW | Memory word for load forms |
| ext_fault | input | 1 | Externally detected memory fault |
| ctl_task_switched | input | 1 | Unit-unavailable control bit |
| ctl_emulate | input | 1 | Emulation control bit |
| ctl_os_save_ok | input | 1 | OS support bit for vector state |
| feat_f64_vec | input | 1 | Feature-present bit |
| dbg_idx | input | IDXW | Register observe index |
| dbg_data | output | 2*QW | Contents of the observed register |
| done | output | 1 | Completion pulse |
| fault_code | output | 2 | 0 none, 1 invalid, 2 unavailable, 3 memory |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | QW | Memory write data |

## Verification
The bench first gives registers nonzero high halves through the reset pattern. This makes a design that clears the high half on a register-to-register move, or keeps it on a memory load, show a wrong high half on the observe port. Requests with several fault conditions at once expose a reversed priority as a wrong code. Those same requests catch a fault that still lets a write through, because a register or mem_we changes. An ext_fault on a register form catches a design that reports the external fault for every form. A load followed at once by a store of the same register catches a store that reads stale data.

// File: rtl/sdm_pkg.sv
package sdm_pkg;

   typedef enum logic [1:0] {
      FLT_NONE  = 2'd0,
      FLT_UNDEF = 2'd1,
      FLT_NODEV = 2'd2,
      FLT_XMEM  = 2'd3
   } flt_e;

   localparam logic [7:0] BYTE_PFX   = 8'hF2;
   localparam logic [7:0] BYTE_ESC   = 8'h0F;
   localparam logic [7:0] BYTE_LOAD  = 8'h10;
   localparam logic [7:0] BYTE_STORE = 8'h11;

   typedef struct packed {
      logic       rf_we;
      logic [2:0] rf_idx;
      logic [2:0] src_idx;
      logic       lo_from_mem;
      logic       clr_hi;
      logic       mem_we;
      flt_e       flt;
   } act_t;

endpackage

// File: rtl/sdm_decode.sv
module sdm_decode
   import sdm_pkg::*;
(
   input  logic       valid,
   input  logic [7:0] pfx,
   input  logic [7:0] esc,
   input  logic [7:0] opc,
   input  logic [7:0] modrm,
   input  logic       xfault,
   input  logic       task_sw,
   input  logic       emul,
   input  logic       os_ok,
   input  logic       feat,
   output act_t       act
);

   logic       seq_ok;
   logic       is_load;
   logic       reg_form;
   logic [2:0] f_reg;
   logic [2:0] f_rm;
   flt_e       flt;

   always_comb begin
      seq_ok   = (pfx == BYTE_PFX) && (esc == BYTE_ESC) &&
                 ((opc == BYTE_LOAD) || (opc == BYTE_STORE));
      is_load  = (opc == BYTE_LOAD);
      reg_form = (modrm[7:6] == 2'b11);
      f_reg    = modrm[5:3];
      f_rm     = modrm[2:0];

      if (!seq_ok || emul || !os_ok || !feat) flt = FLT_UNDEF;
      else if (task_sw)                        flt = FLT_NODEV;
      else if (!reg_form && xfault)            flt = FLT_XMEM;
      else                                     flt = FLT_NONE;

      act         = '0;
      act.flt     = flt;
      act.src_idx = f_reg;
      act.rf_idx  = f_reg;
      if (valid && flt == FLT_NONE) begin
         unique case ({is_load, reg_form})
            2'b11: begin
               act.rf_we   = 1'b1;
               act.src_idx = f_rm;
            end
            2'b10: begin
               act.rf_we       = 1'b1;
               act.lo_from_mem = 1'b1;
               act.clr_hi      = 1'b1;
            end
            2'b01: begin
               act.rf_we  = 1'b1;
               act.rf_idx = f_rm;
            end
            default: act.mem_we = 1'b1;
         endcase
      end
   end

endmodule

// File: rtl/sdm_regfile.sv
module sdm_regfile #(
   parameter int QW = 64,
   parameter int NREG = 8,
   parameter logic [2*QW-1:0] RESET_BASE = '0,
   localparam int IDXW = $clog2(NREG)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [IDXW-1:0] widx,
   input  logic [QW-1:0]   wlo,
   input  logic            clr_hi,
   input  logic [IDXW-1:0] ra_idx,
   output logic [2*QW-1:0] ra_data,
   input  logic [IDXW-1:0] rb_idx,
   output logic [2*QW-1:0] rb_data
);

   logic [2*QW-1:0] ent [NREG];

   for (genvar i = 0; i < NREG; i++) begin : g_ent
      localparam logic [2*QW-1:0] RV = RESET_BASE ^ (2*QW)'(i);
      logic [QW-1:0] lo_q;
      logic [QW-1:0] hi_q;
      logic          hit;

      assign hit = we && (widx == IDXW'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lo_q <= RV[QW-1:0];
            hi_q <= RV[2*QW-1:QW];
         end else if (hit) begin
            lo_q <= wlo;
            if (clr_hi) hi_q <= '0;
         end
      end

      assign ent[i] = {hi_q, lo_q};
   end

   assign ra_data = ent[ra_idx];
   assign rb_data = ent[rb_idx];

endmodule

// File: rtl/sdm_resp.sv
module sdm_resp
   import sdm_pkg::*;
#(
   parameter int QW = 64
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          valid,
   input  flt_e          flt,
   input  logic          we_in,
   input  logic [QW-1:0] wd_in,
   output logic          done,
   output logic [1:0]    fault_code,
   output logic          mem_we,
   output logic [QW-1:0] mem_wdata
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done       <= 1'b0;
         fault_code <= FLT_NONE;
         mem_we     <= 1'b0;
         mem_wdata  <= '0;
      end else begin
         done       <= valid;
         fault_code <= valid ? flt : FLT_NONE;
         mem_we     <= we_in;
         if (we_in) mem_wdata <= wd_in;
      end
   end

endmodule

// File: rtl/sdm_exec.sv
module sdm_exec
   import sdm_pkg::*;
#(
   parameter int QW = 64,
   parameter int NREG = 8,
   parameter logic [2*QW-1:0] RF_RESET_BASE = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210,
   localparam int IDXW = $clog2(NREG)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   input  logic [7:0]      req_prefix,
   input  logic [7:0]      req_escape,
   input  logic [7:0]      req_opcode,
   input  logic [7:0]      req_modrm,
   input  logic [QW-1:0]   mem_rdata,
   input  logic            ext_fault,
   input  logic            ctl_task_switched,
   input  logic            ctl_emulate,
   input  logic            ctl_os_save_ok,
   input  logic            feat_f64_vec,
   input  logic [IDXW-1:0] dbg_idx,
   output logic [2*QW-1:0] dbg_data,
   output logic            done,
   output logic [1:0]      fault_code,
   output logic            mem_we,
   output logic [QW-1:0]   mem_wdata
);

   if (NREG < 2 || NREG > 8 || (NREG & (NREG - 1)) != 0) begin : g_bad_nreg
      $error("NREG must be a power of two between 2 and 8");
   end
   if (QW < 8 || (QW % 8) != 0) begin : g_bad_qw
      $error("QW must be a positive multiple of 8");
   end

   act_t            act;
   logic [2*QW-1:0] src_data;
   logic [QW-1:0]   wr_lo;

   sdm_decode u_dec (
      .valid   (req_valid),
      .pfx     (req_prefix),
      .esc     (req_escape),
      .opc     (req_opcode),
      .modrm   (req_modrm),
      .xfault  (ext_fault),
      .task_sw (ctl_task_switched),
      .emul    (ctl_emulate),
      .os_ok   (ctl_os_save_ok),
      .feat    (feat_f64_vec),
      .act     (act)
   );

   assign wr_lo = act.lo_from_mem ? mem_rdata : src_data[QW-1:0];

   sdm_regfile #(
      .QW         (QW),
      .NREG       (NREG),
      .RESET_BASE (RF_RESET_BASE)
   ) u_rf (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (act.rf_we),
      .widx    (act.rf_idx[IDXW-1:0]),
      .wlo     (wr_lo),
      .clr_hi  (act.clr_hi),
      .ra_idx  (act.src_idx[IDXW-1:0]),
      .ra_data (src_data),
      .rb_idx  (dbg_idx),
      .rb_data (dbg_data)
   );

   sdm_resp #(.QW(QW)) u_resp (
      .clk        (clk),
      .rst_n      (rst_n),
      .valid      (req_valid),
      .flt        (act.flt),
      .we_in      (act.mem_we),
      .wd_in      (src_data[QW-1:0]),
      .done       (done),
      .fault_code (fault_code),
      .mem_we     (mem_we),
      .mem_wdata  (mem_wdata)
   );

endmodule

// File: rtl/sdm_exec_chk.sv
module sdm_exec_chk #(
   parameter int QW = 64
) (
   input logic       clk,
   input logic       rst_n,
   input logic       req_valid,
   input logic [7:0] req_prefix,
   input logic [7:0] req_escape,
   input logic [7:0] req_opcode,
   input logic [7:0] req_modrm,
   input logic       ext_fault,
   input logic       ctl_task_switched,
   input logic       ctl_emulate,
   input logic       ctl_os_save_ok,
   input logic       feat_f64_vec,
   input logic       done,
   input logic [1:0] fault_code,
   input logic       mem_we
);

   logic bytes_ok;
   logic enabled;
   logic mem_form;
   logic is_store;

   assign bytes_ok = req_prefix == 8'hF2 && req_escape == 8'h0F &&
                     (req_opcode == 8'h10 || req_opcode == 8'h11);
   assign enabled  = !ctl_emulate && ctl_os_save_ok && feat_f64_vec;
   assign mem_form = req_modrm[7:6] != 2'b11;
   assign is_store = req_opcode == 8'h11;

   assert_done_after_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> done);
   assert_no_spurious_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !done);
   assert_quiet_fault_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> fault_code == 2'd0);
   assert_bad_bytes_R1: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !bytes_ok |=> fault_code == 2'd1);
   assert_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !enabled |=> fault_code == 2'd1);
   assert_unavailable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && bytes_ok && enabled && ctl_task_switched |=> fault_code == 2'd2);
   assert_ext_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && bytes_ok && enabled && !ctl_task_switched && !mem_form |=> fault_code == 2'd0);
   assert_fault_blocks_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
      fault_code != 2'd0 |-> !mem_we);
   assert_store_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && bytes_ok && enabled && !ctl_task_switched && mem_form && is_store && !ext_fault
      |=> mem_we);
   assert_strobe_with_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> done);

endmodule

bind sdm_exec sdm_exec_chk #(.QW(QW)) u_chk (
   .clk               (clk),
   .rst_n             (rst_n),
   .req_valid         (req_valid),
   .req_prefix        (req_prefix),
   .req_escape        (req_escape),
   .req_opcode        (req_opcode),
   .req_modrm         (req_modrm),
   .ext_fault         (ext_fault),
   .ctl_task_switched (ctl_task_switched),
   .ctl_emulate       (ctl_emulate),
   .ctl_os_save_ok    (ctl_os_save_ok),
   .feat_f64_vec      (feat_f64_vec),
   .done              (done),
   .fault_code        (fault_code),
   .mem_we            (mem_we)
);

// File: tb/tb_sdm_exec.sv
`timescale 1ns/1ps
module tb_sdm_exec;

   localparam logic [127:0] BASE = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         req_valid = 1'b0;
   logic [7:0]   req_prefix = '0, req_escape = '0, req_opcode = '0, req_modrm = '0;
   logic [63:0]  mem_rdata = '0;
   logic         ext_fault = 1'b0;
   logic         ctl_task_switched = 1'b0, ctl_emulate = 1'b0;
   logic         ctl_os_save_ok = 1'b1, feat_f64_vec = 1'b1;
   logic [2:0]   dbg_idx = '0;
   logic [127:0] dbg_data;
   logic         done;
   logic [1:0]   fault_code;
   logic         mem_we;
   logic [63:0]  mem_wdata;

   int n_chk = 0;
   int n_fail = 0;
   logic [127:0] mreg [8];
   logic         exp_we;
   logic [63:0]  exp_wd;

   always #2.5 clk = ~clk;

   sdm_exec #(.QW(64), .NREG(8), .RF_RESET_BASE(BASE)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
      .req_prefix(req_prefix), .req_escape(req_escape), .req_opcode(req_opcode),
      .req_modrm(req_modrm), .mem_rdata(mem_rdata), .ext_fault(ext_fault),
      .ctl_task_switched(ctl_task_switched), .ctl_emulate(ctl_emulate),
      .ctl_os_save_ok(ctl_os_save_ok), .feat_f64_vec(feat_f64_vec),
      .dbg_idx(dbg_idx), .dbg_data(dbg_data), .done(done), .fault_code(fault_code),
      .mem_we(mem_we), .mem_wdata(mem_wdata)
   );

   typedef struct packed {
      logic [7:0]  pf;
      logic [7:0]  es;
      logic [7:0]  op;
      logic [7:0]  mr;
      logic [63:0] md;
      logic [3:0]  ctl;   // {task_switched, emulate, os_save_ok, feat}
      logic        xf;
      logic [1:0]  ef;
   } vec_t;

   localparam int NV = 15;
   localparam vec_t VT [NV] = '{
      '{8'hF2, 8'h0F, 8'h10, 8'h08, 64'hDEAD_BEEF_0000_0001, 4'b0011, 1'b0, 2'd0}, // R4 load r1
      '{8'hF2, 8'h0F, 8'h10, 8'hD1, 64'h0,                   4'b0011, 1'b0, 2'd0}, // R3 r2<-r1
      '{8'hF2, 8'h0F, 8'h11, 8'h10, 64'h0,                   4'b0011, 1'b0, 2'd0}, // R5 store r2
      '{8'hF2, 8'h0F, 8'h11, 8'hDD, 64'h0,                   4'b0011, 1'b0, 2'd0}, // R6 r5<-r3
      '{8'hF2, 8'h0F, 8'h10, 8'h20, 64'h7FF8_0000_0000_0001, 4'b0011, 1'b0, 2'd0}, // R13 NaN r4
      '{8'hF2, 8'h0F, 8'h10, 8'h30, 64'h1111_2222_3333_4444, 4'b0111, 1'b0, 2'd1}, // R7 emulate
      '{8'hF2, 8'h0F, 8'h10, 8'h30, 64'h1111_2222_3333_4444, 4'b0001, 1'b0, 2'd1}, // R7 os off
      '{8'hF2, 8'h0F, 8'h10, 8'hF0, 64'h0,                   4'b0010, 1'b0, 2'd1}, // R7 no feat
      '{8'hF2, 8'h0F, 8'h11, 8'h08, 64'h0,                   4'b1011, 1'b0, 2'd2}, // R8 store blocked
      '{8'hF2, 8'h0F, 8'h11, 8'h08, 64'h0,                   4'b1111, 1'b1, 2'd1}, // R7 over R8
      '{8'hF2, 8'h0F, 8'h10, 8'h30, 64'h5555_6666_7777_8888, 4'b0011, 1'b1, 2'd3}, // R9 ext fault
      '{8'hF2, 8'h0F, 8'h10, 8'hF7, 64'h0,                   4'b0011, 1'b1, 2'd0}, // R9 ignored r6<-r7
      '{8'hF3, 8'h0F, 8'h10, 8'h30, 64'h9,                   4'b0011, 1'b0, 2'd1}, // R1 bad prefix
      '{8'hF2, 8'h0F, 8'h12, 8'h30, 64'h9,                   4'b0011, 1'b0, 2'd1}, // R1 bad opcode
      '{8'hF2, 8'h0F, 8'h11, 8'h38, 64'h0,                   4'b1011, 1'b1, 2'd2}  // R8 over R9
   };

   task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic check_regs(input string req);
      for (int i = 0; i < 8; i++) begin
         dbg_idx = 3'(i);
         #0.2;
         chk(dbg_data === mreg[i], req, dbg_data, mreg[i]);
      end
   endtask

   // Reference behaviour from R3-R6, applied only when no fault is expected (R10).
   task automatic model(input vec_t v);
      logic [2:0] r, m;
      logic       rf;
      r = v.mr[5:3];
      m = v.mr[2:0];
      rf = v.mr[7:6] == 2'b11;
      exp_we = 1'b0;
      exp_wd = '0;
      if (v.ef == 2'd0) begin
         if (v.op == 8'h10 && rf)       mreg[r][63:0] = mreg[m][63:0];
         else if (v.op == 8'h10)        mreg[r] = {64'h0, v.md};
         else if (rf)                   mreg[m][63:0] = mreg[r][63:0];
         else begin
            exp_we = 1'b1;
            exp_wd = mreg[r][63:0];
         end
      end
   endtask

   task automatic drive(input vec_t v);
      req_valid = 1'b1;
      req_prefix = v.pf; req_escape = v.es; req_opcode = v.op; req_modrm = v.mr;
      mem_rdata = v.md; ext_fault = v.xf;
      {ctl_task_switched, ctl_emulate, ctl_os_save_ok, feat_f64_vec} = v.ctl;
   endtask

   task automatic check_resp(input vec_t v, input string req);
      chk(done === 1'b1, {req, " done"}, 128'(done), 128'd1);
      chk(fault_code === v.ef, {req, " fault"}, 128'(fault_code), 128'(v.ef));
      chk(mem_we === exp_we, {req, " mem_we"}, 128'(mem_we), 128'(exp_we));
      if (exp_we) chk(mem_wdata === exp_wd, {req, " wdata"}, 128'(mem_wdata), 128'(exp_wd));
   endtask

   task automatic reset_model();
      for (int i = 0; i < 8; i++) mreg[i] = BASE ^ 128'(i);
   endtask

   initial begin
      vec_t va, vb;
      reset_model();
      repeat (3) @(negedge clk);
      // R12: reset state
      chk(done === 1'b0, "R12 done", 128'(done), 128'd0);
      chk(mem_we === 1'b0, "R12 mem_we", 128'(mem_we), 128'd0);
      chk(fault_code === 2'd0, "R12 fault", 128'(fault_code), 128'd0);
      check_regs("R12 reset regs");
      rst_n = 1'b1;
      @(negedge clk);

      // Vector table: R1, R3-R10, R13
      for (int k = 0; k < NV; k++) begin
         drive(VT[k]);
         model(VT[k]);
         @(negedge clk);
         req_valid = 1'b0;
         check_resp(VT[k], $sformatf("R1-vector%0d R10", k));
         check_regs($sformatf("R3 R4 R6 R10 vector%0d", k));
         @(negedge clk);
         chk(done === 1'b0, "R11 done drops", 128'(done), 128'd0);
         chk(fault_code === 2'd0, "R11 fault idle", 128'(fault_code), 128'd0);
      end

      // R11: back-to-back, store sees the preceding load
      va = '{8'hF2, 8'h0F, 8'h10, 8'h00, 64'hCAFE_F00D_1234_5678, 4'b0011, 1'b0, 2'd0};
      vb = '{8'hF2, 8'h0F, 8'h11, 8'h00, 64'h0,                   4'b0011, 1'b0, 2'd0};
      drive(va); model(va);
      @(negedge clk);
      check_resp(va, "R11 first of pair");
      drive(vb); model(vb);
      @(negedge clk);
      req_valid = 1'b0;
      check_resp(vb, "R11 second of pair");
      chk(mem_wdata === 64'hCAFE_F00D_1234_5678, "R11 forward", 128'(mem_wdata), 128'hCAFE_F00D_1234_5678);
      @(negedge clk);
      chk(done === 1'b0 && mem_we === 1'b0, "R11 idle after pair", 128'({done, mem_we}), 128'd0);

      // R12: reset mid-run restores register pattern
      rst_n = 1'b0;
      @(negedge clk);
      reset_model();
      check_regs("R12 reset again");
      rst_n = 1'b1;
      @(negedge clk);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(5.0 * 100000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule